// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that moves a run of equally sized elements between a fixed device address and an incrementing memory address. Four channel words (device address, memory address, size, link) are loaded through a small write port while the channel is idle. A start command then picks the operating mode. Direct mode runs the transfer held in those four words. List mode begins by reading a four-word descriptor from memory at the address in the link word, and then runs it.

Each element is moved by one read on the master port followed by one write. The source and target of that pair depend on the direction bit latched at start. The link word of the running descriptor controls what happens when its element count reaches zero. Either the channel fetches another descriptor or it stops, and it may raise a completion pulse. A malformed size word makes the channel drop that descriptor, raise an error pulse and stop.

Top module: `dma_chain_chan`

## Requirements
- R1: After synchronous reset, status is 0, mode_q is 0, bus_req is low, and done_pulse and err_pulse are low.
- R2: With start_dir = 1 (memory to device), element i is read from memory address + i*step and written to the device address, and the written data equals the data that was read.
- R3: With start_dir = 0 (device to memory), every element is read from the device address and written to memory address + i*step, carrying the data that was read.
- R4: Size bits 13:12 give the element width and so the address step: code 3 steps by 1, code 2 by 2 and code 0 by 4. Size bits 10:0 hold the element count.
- R5: start_mode = 1 (list) reads four words from the link word with bits 1:0 cleared, at offsets 0x0, 0x4, 0x8 and 0xC, in that order, into device address, memory address, size and link. Status is 1 during these reads.
- R6: Link bit 1 = 1 chains to the descriptor at the link address. Link bit 1 = 0 ends the run, returning status to 0 and mode_q to 0. mode_q holds the started mode while the run is going.
- R7: done_pulse is high for exactly one cycle after a descriptor whose link bit 0 is 1 completes, and stays low otherwise.
- R8: A size word with width code 1, a count of 0, or a count above 0x3FF (1- or 2-byte width) or 0x7FF (4-byte width) raises err_pulse for one cycle. No data is moved for that descriptor, and the channel ends at status 0 with mode_q 0.
- R9: Status is 3 for every granted data read and data write. Status is 2 in the single cycles between fetching and moving, and between a finished descriptor and what follows.
- R10: start with start_mode 0 or 3 is ignored. start and channel-word writes are ignored while the channel is not idle.
- R11: A request that is not granted stays asserted, with its address and direction unchanged, until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Channel-word write strobe (idle only) |
| cfg_sel | input | 2 | Word select: 0 device, 1 memory, 2 size, 3 link |
| cfg_wdata | input | 32 | Channel-word write data |
| start | input | 1 | Start command |
| start_mode | input | 2 | 1 list, 2 direct; 0 and 3 ignored |
| start_dir | input | 1 | 1 memory to device, 0 device to memory |
| bus_req | output | 1 | Master request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 32 | Master address |
| bus_wdata | output | 32 | Write data |
| bus_gnt | input | 1 | Grant; completes the access this cycle |
| bus_rdata | input | 32 | Read data, valid with grant on a read |
| status | output | 2 | 0 idle, 1 descriptor read, 2 wait, 3 data access |
| mode_q | output | 2 | Active mode, 0 when stopped |
| done_pulse | output | 1 | Completion pulse |
| err_pulse | output | 1 | Malformed-descriptor pulse |

## Verification
The bench builds the channel with the default 11-bit count field. At that width the largest legal word-width count (2047 elements) and the narrow-width limit (1023 legal, 1024 rejected) both fit in a short run. The bench therefore walks both count ceilings and the off-by-one rejection directly. It also gates grants on alternate cycles, so held requests are exercised in fetch and data phases alike.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int DW        = 32;
  localparam int NUM_WORDS = 4;
  localparam int W_DEV     = 0;
  localparam int W_MEM     = 1;
  localparam int W_SIZE    = 2;
  localparam int W_NEXT    = 3;
  localparam int WC_LSB    = 12;

  localparam logic [1:0] MODE_OFF    = 2'd0;
  localparam logic [1:0] MODE_LIST   = 2'd1;
  localparam logic [1:0] MODE_SINGLE = 2'd2;

  localparam logic [1:0] STS_IDLE = 2'd0;
  localparam logic [1:0] STS_DESC = 2'd1;
  localparam logic [1:0] STS_WAIT = 2'd2;
  localparam logic [1:0] STS_DATA = 2'd3;

  localparam logic [1:0] WC_WORD = 2'd0;
  localparam logic [1:0] WC_BAD  = 2'd1;
  localparam logic [1:0] WC_HALF = 2'd2;
  localparam logic [1:0] WC_BYTE = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_RD, ST_WR, ST_END
  } chan_state_e;
endpackage

// File: rtl/dma_desc_file.sv
module dma_desc_file
  import dma_chain_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [1:0]                      idx,
  input  logic [DW-1:0]                   wdata,
  output logic [NUM_WORDS-1:0][DW-1:0]    words_q
);
  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (rst)
        words_q[k] <= '0;
      else if (we && idx == 2'(k))
        words_q[k] <= wdata;
    end
  end
endmodule

// File: rtl/dma_size_decode.sv
module dma_size_decode
  import dma_chain_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic [DW-1:0]    size_word,
  output logic [2:0]       step,
  output logic [CNT_W-1:0] count,
  output logic             bad
);
  localparam logic [CNT_W-1:0] NARROW_MAX = CNT_W'((1 << (CNT_W - 1)) - 1);

  logic [1:0] wcode;
  logic       narrow;

  always_comb begin
    wcode  = size_word[WC_LSB+1:WC_LSB];
    count  = size_word[CNT_W-1:0];
    narrow = (wcode == WC_BYTE) || (wcode == WC_HALF);
    case (wcode)
      WC_BYTE: step = 3'd1;
      WC_HALF: step = 3'd2;
      WC_WORD: step = 3'd4;
      default: step = 3'd0;
    endcase
    bad = (wcode == WC_BAD) || (count == '0) || (narrow && count > NARROW_MAX);
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chain_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [1:0]                   start_mode,
  input  logic                         start_dir,
  input  logic [NUM_WORDS-1:0][DW-1:0] regs_q,
  input  logic [2:0]                   dec_step,
  input  logic [CNT_W-1:0]             dec_count,
  input  logic                         dec_bad,
  output logic                         rf_we,
  output logic [1:0]                   rf_idx,
  output logic [DW-1:0]                rf_wdata,
  output logic                         bus_req,
  output logic                         bus_we,
  output logic [DW-1:0]                bus_addr,
  output logic [DW-1:0]                bus_wdata,
  input  logic                         bus_gnt,
  input  logic [DW-1:0]                bus_rdata,
  output logic [1:0]                   status,
  output logic [1:0]                   mode_q,
  output logic                         done_pulse,
  output logic                         err_pulse,
  output logic                         idle
);
  chan_state_e      state;
  logic [1:0]       widx;
  logic [DW-1:0]    fbase;
  logic [DW-1:0]    cur_mem;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       step_q;
  logic             dir_q;
  logic [DW-1:0]    hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      widx       <= '0;
      fbase      <= '0;
      cur_mem    <= '0;
      cnt        <= '0;
      step_q     <= '0;
      dir_q      <= 1'b0;
      hold_q     <= '0;
      mode_q     <= MODE_OFF;
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start && (start_mode == MODE_LIST || start_mode == MODE_SINGLE)) begin
            mode_q <= start_mode;
            dir_q  <= start_dir;
            if (start_mode == MODE_LIST) begin
              fbase <= {regs_q[W_NEXT][DW-1:2], 2'b00};
              widx  <= '0;
              state <= ST_FETCH;
            end else begin
              state <= ST_CHECK;
            end
          end
        end
        ST_FETCH: begin
          if (bus_gnt) begin
            widx <= widx + 2'd1;
            if (widx == 2'd3) state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (dec_bad) begin
            err_pulse <= 1'b1;
            mode_q    <= MODE_OFF;
            state     <= ST_IDLE;
          end else begin
            cur_mem <= regs_q[W_MEM];
            cnt     <= dec_count;
            step_q  <= dec_step;
            state   <= ST_RD;
          end
        end
        ST_RD: begin
          if (bus_gnt) begin
            hold_q <= bus_rdata;
            state  <= ST_WR;
          end
        end
        ST_WR: begin
          if (bus_gnt) begin
            cur_mem <= cur_mem + DW'(step_q);
            cnt     <= cnt - CNT_W'(1);
            state   <= (cnt == CNT_W'(1)) ? ST_END : ST_RD;
          end
        end
        ST_END: begin
          done_pulse <= regs_q[W_NEXT][0];
          if (regs_q[W_NEXT][1]) begin
            fbase <= {regs_q[W_NEXT][DW-1:2], 2'b00};
            widx  <= '0;
            state <= ST_FETCH;
          end else begin
            mode_q <= MODE_OFF;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rf_we     = (state == ST_FETCH) && bus_gnt;
    rf_idx    = widx;
    rf_wdata  = bus_rdata;
    bus_req   = (state == ST_FETCH) || (state == ST_RD) || (state == ST_WR);
    bus_we    = (state == ST_WR);
    bus_wdata = hold_q;
    idle      = (state == ST_IDLE);
    case (state)
      ST_FETCH: bus_addr = fbase + {28'd0, widx, 2'b00};
      ST_RD:    bus_addr = dir_q ? cur_mem : regs_q[W_DEV];
      ST_WR:    bus_addr = dir_q ? regs_q[W_DEV] : cur_mem;
      default:  bus_addr = '0;
    endcase
    case (state)
      ST_IDLE:           status = STS_IDLE;
      ST_FETCH:          status = STS_DESC;
      ST_RD, ST_WR:      status = STS_DATA;
      default:           status = STS_WAIT;
    endcase
  end

  // R11: an ungranted request is held unchanged
  a_r11_hold_request: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);

  // R8: an error pulse coincides with a stopped channel
  a_r8_err_stopped: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (status == STS_IDLE && mode_q == MODE_OFF && !done_pulse));

  // R5: descriptor fetch issues aligned reads only
  a_r5_fetch_reads: assert property (@(posedge clk) disable iff (rst)
    (status == STS_DESC) |-> (bus_req && !bus_we && bus_addr[1:0] == 2'b00));

  // R6: a finished last descriptor stops the channel
  a_r6_last_stops: assert property (@(posedge clk) disable iff (rst)
    (state == ST_END && !regs_q[W_NEXT][1]) |=> (mode_q == MODE_OFF && status == STS_IDLE));
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          start,
  input  logic [1:0]    start_mode,
  input  logic          start_dir,
  output logic          bus_req,
  output logic          bus_we,
  output logic [DW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  output logic [1:0]    status,
  output logic [1:0]    mode_q,
  output logic          done_pulse,
  output logic          err_pulse
);
  logic [NUM_WORDS-1:0][DW-1:0] words_q;
  logic                         ctl_we, ctl_idle, file_we;
  logic [1:0]                   ctl_idx, file_idx;
  logic [DW-1:0]                ctl_wdata, file_wdata;
  logic [2:0]                   dec_step;
  logic [CNT_W-1:0]             dec_count;
  logic                         dec_bad;

  // Host writes land only while idle; fetch writes otherwise.
  always_comb begin
    file_we    = ctl_we || (cfg_we && ctl_idle);
    file_idx   = ctl_we ? ctl_idx : cfg_sel;
    file_wdata = ctl_we ? ctl_wdata : cfg_wdata;
  end

  dma_desc_file u_file (
    .clk(clk), .rst(rst), .we(file_we), .idx(file_idx),
    .wdata(file_wdata), .words_q(words_q)
  );

  dma_size_decode #(.CNT_W(CNT_W)) u_dec (
    .size_word(words_q[W_SIZE]), .step(dec_step),
    .count(dec_count), .bad(dec_bad)
  );

  dma_chan_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .start_mode(start_mode),
    .start_dir(start_dir), .regs_q(words_q), .dec_step(dec_step),
    .dec_count(dec_count), .dec_bad(dec_bad), .rf_we(ctl_we),
    .rf_idx(ctl_idx), .rf_wdata(ctl_wdata), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .status(status),
    .mode_q(mode_q), .done_pulse(done_pulse), .err_pulse(err_pulse),
    .idle(ctl_idle)
  );
endmodule

// File: tb/dma_chain_chan_tb.sv
module dma_chain_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DEV = 32'h8000_0010;
  localparam logic [31:0] MBASE = 32'h0000_0100;
  // {mode, dir, wcode, count, irq, stall, exp_err, pad}
  localparam logic [23:0] VEC [10] = '{
    {2'd2, 1'b1, 2'd0, 11'd3,    1'b1, 1'b0, 1'b0, 5'd0},
    {2'd2, 1'b0, 2'd3, 11'd4,    1'b0, 1'b1, 1'b0, 5'd0},
    {2'd1, 1'b1, 2'd2, 11'd2,    1'b1, 1'b1, 1'b0, 5'd0},
    {2'd1, 1'b0, 2'd0, 11'd5,    1'b1, 1'b0, 1'b0, 5'd0},
    {2'd2, 1'b1, 2'd1, 11'd2,    1'b1, 1'b0, 1'b1, 5'd0},
    {2'd2, 1'b0, 2'd0, 11'd0,    1'b1, 1'b0, 1'b1, 5'd0},
    {2'd1, 1'b1, 2'd3, 11'd1024, 1'b1, 1'b0, 1'b1, 5'd0},
    {2'd2, 1'b0, 2'd0, 11'd2047, 1'b0, 1'b0, 1'b0, 5'd0},
    {2'd2, 1'b1, 2'd2, 11'd1023, 1'b1, 1'b0, 1'b0, 5'd0},
    {2'd2, 1'b1, 2'd2, 11'd1024, 1'b0, 1'b1, 1'b1, 5'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic start = 1'b0;
  logic [1:0] start_mode = '0;
  logic start_dir = 1'b0;
  logic bus_req, bus_we, bus_gnt, done_pulse, err_pulse;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0] status, mode_q;

  logic [31:0] mem [1024];
  logic stall_en = 1'b0;
  logic phase = 1'b0;
  int n_chk = 0, n_fail = 0;
  int wr_n = 0, rd_n = 0, dev_rd_n = 0, s1_n = 0, s3_n = 0, done_n = 0, err_n = 0;
  logic [31:0] wr_addr [8192];
  logic [31:0] wr_data [8192];
  logic [31:0] rd_addr [8192];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_chan u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .start(start), .start_mode(start_mode), .start_dir(start_dir),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .status(status), .mode_q(mode_q),
    .done_pulse(done_pulse), .err_pulse(err_pulse)
  );

  always @(posedge clk) phase <= ~phase;
  assign bus_gnt   = bus_req & (~stall_en | phase);
  assign bus_rdata = bus_addr[31] ? (32'hD000_0000 + 32'(dev_rd_n)) : mem[bus_addr[11:2]];

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_req && bus_gnt) begin
        if (bus_we) begin
          wr_addr[wr_n] <= bus_addr;
          wr_data[wr_n] <= bus_wdata;
          wr_n <= wr_n + 1;
          if (!bus_addr[31]) dev_rd_n <= dev_rd_n + 1;
        end else begin
          rd_addr[rd_n] <= bus_addr;
          rd_n <= rd_n + 1;
        end
        if (status == 2'd1) s1_n <= s1_n + 1;
        if (status == 2'd3) s3_n <= s3_n + 1;
      end
      if (done_pulse) done_n <= done_n + 1;
      if (err_pulse) err_n <= err_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic kick(input logic [1:0] m, input logic d);
    @(negedge clk);
    start = 1'b1; start_mode = m; start_dir = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (!(status == 2'd0 && mode_q == 2'd0)) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_vec(input int n);
    logic [23:0] v;
    logic [1:0] m, wc;
    logic d, irq, st, xerr;
    logic [10:0] cnt;
    logic [31:0] size, step;
    int wb, rb, db, s1b, s3b, dnb, erb, exp_n, bad, first_i;
    v = VEC[n];
    m = v[23:22]; d = v[21]; wc = v[20:19]; cnt = v[18:8];
    irq = v[7]; st = v[6]; xerr = v[5];
    size = (32'(wc) << 12) | 32'(cnt);
    step = (wc == 2'd3) ? 32'd1 : (wc == 2'd2) ? 32'd2 : 32'd4;
    stall_en = st;
    cfg_write(2'd0, DEV);
    cfg_write(2'd1, MBASE);
    if (m == 2'd1) begin
      mem[16] = DEV; mem[17] = MBASE; mem[18] = size; mem[19] = {31'd0, irq};
      cfg_write(2'd2, 32'h0000_3000);
      cfg_write(2'd3, 32'h0000_0042);
    end else begin
      cfg_write(2'd2, size);
      cfg_write(2'd3, {31'd0, irq});
    end
    wb = wr_n; rb = rd_n; db = dev_rd_n; s1b = s1_n; s3b = s3_n; dnb = done_n; erb = err_n;
    kick(m, d);
    wait_idle();
    exp_n = xerr ? 0 : int'(cnt);
    chk(wr_n - wb == exp_n, d ? "R2 write count" : "R3 write count", 32'(wr_n - wb), 32'(exp_n));
    bad = 0; first_i = 0;
    for (int i = 0; i < exp_n; i++) begin
      logic [31:0] ea, ed;
      if (d) begin
        ea = DEV;
        ed = mem[10'(((MBASE + 32'(i) * step) >> 2))];
      end else begin
        ea = MBASE + 32'(i) * step;
        ed = 32'hD000_0000 + 32'(db + i);
      end
      if (wr_addr[wb+i] !== ea || wr_data[wb+i] !== ed) begin
        if (bad == 0) first_i = i;
        bad++;
      end
    end
    chk(bad == 0, d ? "R2/R4 element addr/data" : "R3/R4 element addr/data",
        (exp_n > 0) ? wr_addr[wb+first_i] : 32'd0, 32'(first_i));
    chk(done_n - dnb == ((irq && !xerr) ? 1 : 0), "R7 done pulses",
        32'(done_n - dnb), (irq && !xerr) ? 32'd1 : 32'd0);
    chk(err_n - erb == (xerr ? 1 : 0), "R8 error pulses", 32'(err_n - erb), {31'd0, xerr});
    chk(s3_n - s3b == 2 * exp_n, "R9 data accesses at status 3", 32'(s3_n - s3b), 32'(2 * exp_n));
    chk(mode_q == 2'd0 && status == 2'd0, "R6 stopped at end", {30'd0, mode_q}, 32'd0);
    if (m == 2'd1) begin
      chk(s1_n - s1b == 4 && rd_addr[rb] == 32'h40 && rd_addr[rb+3] == 32'h4C,
          "R5 fetch order", rd_addr[rb+3], 32'h4C);
    end
    stall_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all-requirements actual=%h expected=%h", 32'd1, 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int wb, rb, dnb, bad;
    for (int k = 0; k < 1024; k++) mem[k] = 32'hA500_0000 | 32'(k);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(status == 2'd0 && mode_q == 2'd0 && !bus_req && !done_pulse && !err_pulse,
        "R1 reset state", {27'd0, status, mode_q, bus_req}, 32'd0);

    for (int n = 0; n < 10; n++) run_vec(n);

    // R6/R7/R5 two-descriptor chain, interrupt on the first only
    mem[16] = DEV; mem[17] = MBASE;        mem[18] = 32'd2; mem[19] = 32'h0000_0063;
    mem[24] = DEV; mem[25] = 32'h0000_0200; mem[26] = 32'd1; mem[27] = 32'h0000_0000;
    cfg_write(2'd3, 32'h0000_0040);
    wb = wr_n; rb = rd_n; dnb = done_n;
    kick(2'd1, 1'b1);
    chk(mode_q == 2'd1, "R6 mode held while running", {30'd0, mode_q}, 32'd1);
    wait_idle();
    chk(wr_n - wb == 3, "R6 chained element count", 32'(wr_n - wb), 32'd3);
    chk(wr_data[wb+2] == mem[128], "R6 second descriptor data", wr_data[wb+2], mem[128]);
    chk(rd_addr[rb+6] == 32'h60 && rd_addr[rb+9] == 32'h6C, "R5 chained fetch address",
        rd_addr[rb+6], 32'h60);
    chk(done_n - dnb == 1, "R7 one done for the chain", 32'(done_n - dnb), 32'd1);

    // R10 start with reserved modes
    kick(2'd3, 1'b1);
    chk(status == 2'd0 && mode_q == 2'd0 && !bus_req, "R10 mode 3 ignored",
        {30'd0, status}, 32'd0);
    kick(2'd0, 1'b0);
    chk(status == 2'd0 && mode_q == 2'd0 && !bus_req, "R10 mode 0 ignored",
        {30'd0, status}, 32'd0);

    // R10 writes and start while busy, R11 under stalls
    cfg_write(2'd0, DEV);
    cfg_write(2'd2, 32'd6);
    cfg_write(2'd3, 32'd0);
    stall_en = 1'b1;
    wb = wr_n;
    kick(2'd2, 1'b1);
    cfg_write(2'd0, 32'h8000_0F00);
    kick(2'd1, 1'b1);
    chk(mode_q == 2'd2, "R10 start ignored while busy", {30'd0, mode_q}, 32'd2);
    wait_idle();
    stall_en = 1'b0;
    bad = 0;
    for (int i = 0; i < 6; i++) if (wr_addr[wb+i] != DEV) bad++;
    chk(wr_n - wb == 6 && bad == 0, "R10/R11 busy write ignored, stalled run",
        32'(bad), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule